// File: doc/BRIEF.md
# DMA Interrupt and Control Register Bank

This block is the software-visible control plane of a multichannel DMA engine with eight transmit and eight receive channels. It sits on a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. The channel engines report into it with single-cycle pulses: a completion sets a channel's raw interrupt bit, an acknowledge clears it, and an error report latches an error code and channel number. The bank drives one combined interrupt line back to the host. It also drives the global enables, the DMA control bits, the receive buffer offset and one-cycle teardown requests towards the engines.

Interrupts come in three groups: transmit, receive and a DMA-level group whose only live bit is the host-error bit. Each group has a raw status register, a mask and a masked status. The mask can be changed only through a write-one-to-set address and a write-one-to-clear address. A state machine with the states ARMED and FIRED drives the combined interrupt. ARMED moves to FIRED on the edge after any masked bit is seen. FIRED moves back to ARMED on a write to the end-of-interrupt address, or when a soft reset clears the bank. A second state machine with the states IDLE and CLEARING runs the soft reset. A write of 1 moves IDLE to CLEARING. After a fixed count, CLEARING moves back to IDLE and the reset bit clears by itself.

Top module: `dma_irq_regbank`

## Requirements
- R1: After rst_n is released, every readable address returns 0 while engine_idle is low, and irq_out, chan_reset, tx_enable, rx_enable, idle_cmd, tx_td_req and rx_td_req are all low.
- R2: Bit 0 written to 0x04 sets tx_enable and bit 0 written to 0x14 sets rx_enable. Each reads back at bit 0 of its address, and writing 0 clears it.
- R3: A pulse on tx_done_pulse[n] sets bit n of 0x80, and a pulse on rx_done_pulse[n] sets bit n of 0xA0. The matching ack pulse clears the bit. A done pulse and an ack pulse in the same cycle leave the bit set. tx_err_valid or rx_err_valid sets bit 1 of 0xB0, and host_err_ack clears it.
- R4: A 1 written to bit n of 0x88 sets mask bit n, and a 1 written to bit n of 0x8C clears it. Bits written as 0 leave the mask unchanged. The mask reads back at both addresses. The receive group uses 0xA8 and 0xAC, and the DMA-level group uses 0xB8 and 0xBC, where only bit 1 exists.
- R5: Addresses 0x84, 0xA4 and 0xB4 read the raw status of their group ANDed with that group's mask.
- R6: irq_out rises on the edge after any masked bit is set. It stays high until a write to 0x94, then drops, and it rises again on the following edge if a masked bit is still set.
- R7: A write with bit 0 set to 0x1C makes 0x1C read 1 and chan_reset high for exactly 16 cycles. Over that window it clears all raw status, all masks, the error fields and irq_out. Writes and channel pulses are ignored during the window. The enables, the DMA control bits and the buffer offset are kept.
- R8: 0x20 holds transmit fixed priority at bit 0, receive ownership flip at bit 1, receive offset/length update at bit 2 and copy error frames at bit 4, each driving its output. A write with bit 3 set gives a one-cycle idle_cmd pulse, and bit 3 reads 0.
- R9: 0x24 reads engine_idle at bit 31, transmit error code at 23:20, transmit error channel at 18:16, receive error code at 15:12 and receive error channel at 10:8. An error report latches its fields and takes priority over a write in the same cycle. The fields can also be written.
- R10: 0x28 holds a 16-bit receive buffer offset in bits 15:0 and drives rx_buf_offset.
- R11: A write of value n (bits 2:0) to 0x08 gives a one-cycle pulse on tx_td_req[n], and 0x18 does the same on rx_td_req[n]. Both addresses read 0.
- R12: Any address that is not mapped, and the end-of-interrupt address 0x94, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_done_pulse | input | 8 | Transmit completion per channel |
| tx_ack_pulse | input | 8 | Transmit interrupt acknowledge per channel |
| rx_done_pulse | input | 8 | Receive completion per channel |
| rx_ack_pulse | input | 8 | Receive interrupt acknowledge per channel |
| tx_err_valid | input | 1 | Transmit error report strobe |
| tx_err_code | input | 4 | Transmit error code |
| tx_err_chan | input | 3 | Transmit error channel |
| rx_err_valid | input | 1 | Receive error report strobe |
| rx_err_code | input | 4 | Receive error code |
| rx_err_chan | input | 3 | Receive error channel |
| host_err_ack | input | 1 | Clears the host-error raw bit |
| engine_idle | input | 1 | Engine idle indication |
| irq_out | output | 1 | Combined interrupt |
| chan_reset | output | 1 | High during soft reset |
| tx_enable | output | 1 | Transmit engine enable |
| rx_enable | output | 1 | Receive engine enable |
| tx_prio_fixed | output | 1 | Fixed transmit priority |
| rx_own_flip | output | 1 | Receive ownership flip |
| rx_len_update | output | 1 | Receive offset/length update |
| copy_err_frames | output | 1 | Copy error frames |
| idle_cmd | output | 1 | One-cycle idle command |
| rx_buf_offset | output | 16 | Receive buffer offset |
| tx_td_req | output | 8 | One-hot transmit teardown request |
| rx_td_req | output | 8 | One-hot receive teardown request |

## Verification
The assertions assume that rst_n is low before the first clock edge. They also assume the bus holds each write for a single cycle. Done and ack pulses may arrive in any combination, including on the same channel in the same cycle. The bench changes every input one time unit after the rising edge and holds it until the next one, so the block never sees a change at its sampling edge. Its random phase only writes or reads through the bus and pulses the channel inputs. It starts a soft reset now and then, so writes and pulses also land inside the clearing window.

// File: rtl/dirb_pkg.sv
package dirb_pkg;

    localparam logic [7:0] OFS_TX_CTRL   = 8'h04;
    localparam logic [7:0] OFS_TX_TD     = 8'h08;
    localparam logic [7:0] OFS_RX_CTRL   = 8'h14;
    localparam logic [7:0] OFS_RX_TD     = 8'h18;
    localparam logic [7:0] OFS_SRST      = 8'h1C;
    localparam logic [7:0] OFS_DMA_CTRL  = 8'h20;
    localparam logic [7:0] OFS_DMA_STAT  = 8'h24;
    localparam logic [7:0] OFS_RX_OFS    = 8'h28;
    localparam logic [7:0] OFS_TX_RAW    = 8'h80;
    localparam logic [7:0] OFS_TX_MSKD   = 8'h84;
    localparam logic [7:0] OFS_TX_MSET   = 8'h88;
    localparam logic [7:0] OFS_TX_MCLR   = 8'h8C;
    localparam logic [7:0] OFS_EOI       = 8'h94;
    localparam logic [7:0] OFS_RX_RAW    = 8'hA0;
    localparam logic [7:0] OFS_RX_MSKD   = 8'hA4;
    localparam logic [7:0] OFS_RX_MSET   = 8'hA8;
    localparam logic [7:0] OFS_RX_MCLR   = 8'hAC;
    localparam logic [7:0] OFS_HE_RAW    = 8'hB0;
    localparam logic [7:0] OFS_HE_MSKD   = 8'hB4;
    localparam logic [7:0] OFS_HE_MSET   = 8'hB8;
    localparam logic [7:0] OFS_HE_MCLR   = 8'hBC;

    localparam int unsigned ERR_CODE_W = 4;
    localparam int unsigned ERR_CHAN_W = 3;
    localparam int unsigned HE_GRP_W   = 2;

    typedef enum logic {
        RS_IDLE,
        RS_CLEAR
    } rst_state_e;

    typedef enum logic {
        IC_ARMED,
        IC_FIRED
    } irq_state_e;

    typedef struct packed {
        logic [ERR_CODE_W-1:0] code;
        logic [ERR_CHAN_W-1:0] chan;
    } err_field_t;

endpackage

// File: rtl/dirb_reset_seq.sv
module dirb_reset_seq
    import dirb_pkg::*;
#(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    rst_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RS_IDLE: begin
                if (start) begin
                    st_d  = RS_CLEAR;
                    cnt_d = LOAD;
                end
            end
            RS_CLEAR: begin
                if (cnt_q == '0) st_d = RS_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        busy = (st_q == RS_CLEAR);
    end

    assert_rst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_rst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0) |=> !busy);
endmodule

// File: rtl/dirb_irq_group.sv
module dirb_irq_group #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] ack_pulse,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);
    logic [W-1:0] mask_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic raw_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             raw_q <= 1'b0;
            else if (clr_all)       raw_q <= 1'b0;
            else if (set_pulse[i])  raw_q <= 1'b1;
            else if (ack_pulse[i])  raw_q <= 1'b0;
        end
        assign raw[i] = raw_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (clr_all) mask_q <= '0;
        else if (wr_set)  mask_q <= mask_q | wdata;
        else if (wr_clr)  mask_q <= mask_q & ~wdata;
    end

    assign mask   = mask_q;
    assign masked = raw & mask_q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && (|set_pulse)) |=> ((raw & $past(set_pulse)) == $past(set_pulse)));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !wr_set && !wr_clr) |=> $stable(mask));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (raw == '0 && mask == '0));
endmodule

// File: rtl/dirb_irq_combiner.sv
module dirb_irq_combiner
    import dirb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pending,
    input  logic eoi,
    output logic irq
);
    irq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IC_ARMED: if (!clr && pending) st_d = IC_FIRED;
            IC_FIRED: if (clr || eoi)      st_d = IC_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IC_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        irq = (st_q == IC_FIRED);
    end

    assert_irq_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && pending && !clr) |=> irq);
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi && !clr) |=> irq);
    assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (eoi || clr)) |=> !irq);
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
    import dirb_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RST_CYCLES = 16,
    parameter int unsigned OFS_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0]     tx_done_pulse,
    input  logic [NUM_CH-1:0]     tx_ack_pulse,
    input  logic [NUM_CH-1:0]     rx_done_pulse,
    input  logic [NUM_CH-1:0]     rx_ack_pulse,
    input  logic                  tx_err_valid,
    input  logic [ERR_CODE_W-1:0] tx_err_code,
    input  logic [ERR_CHAN_W-1:0] tx_err_chan,
    input  logic                  rx_err_valid,
    input  logic [ERR_CODE_W-1:0] rx_err_code,
    input  logic [ERR_CHAN_W-1:0] rx_err_chan,
    input  logic                  host_err_ack,
    input  logic                  engine_idle,
    output logic                  irq_out,
    output logic                  chan_reset,
    output logic                  tx_enable,
    output logic                  rx_enable,
    output logic                  tx_prio_fixed,
    output logic                  rx_own_flip,
    output logic                  rx_len_update,
    output logic                  copy_err_frames,
    output logic                  idle_cmd,
    output logic [OFS_W-1:0]      rx_buf_offset,
    output logic [NUM_CH-1:0]     tx_td_req,
    output logic [NUM_CH-1:0]     rx_td_req
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic busy, wr_ok, srst_go, clr_all;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr_ok   = bus_we && !busy;
    assign srst_go = wr_ok && hit(bus_addr, OFS_SRST) && bus_wdata[0];
    assign clr_all = srst_go || busy;

    dirb_reset_seq #(.CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_go),
        .busy  (busy)
    );

    // interrupt groups
    logic [NUM_CH-1:0]   tx_raw, tx_mask, tx_mskd;
    logic [NUM_CH-1:0]   rx_raw, rx_mask, rx_mskd;
    logic [HE_GRP_W-1:0] he_raw, he_mask, he_mskd;

    dirb_irq_group #(.W(NUM_CH)) u_tx_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .set_pulse (tx_done_pulse),
        .ack_pulse (tx_ack_pulse),
        .wr_set    (wr_ok && hit(bus_addr, OFS_TX_MSET)),
        .wr_clr    (wr_ok && hit(bus_addr, OFS_TX_MCLR)),
        .wdata     (bus_wdata[NUM_CH-1:0]),
        .raw       (tx_raw),
        .mask      (tx_mask),
        .masked    (tx_mskd)
    );

    dirb_irq_group #(.W(NUM_CH)) u_rx_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .set_pulse (rx_done_pulse),
        .ack_pulse (rx_ack_pulse),
        .wr_set    (wr_ok && hit(bus_addr, OFS_RX_MSET)),
        .wr_clr    (wr_ok && hit(bus_addr, OFS_RX_MCLR)),
        .wdata     (bus_wdata[NUM_CH-1:0]),
        .raw       (rx_raw),
        .mask      (rx_mask),
        .masked    (rx_mskd)
    );

    // only bit 1 (host error) of the DMA-level group is live
    dirb_irq_group #(.W(HE_GRP_W)) u_he_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .set_pulse ({tx_err_valid || rx_err_valid, 1'b0}),
        .ack_pulse ({host_err_ack, 1'b0}),
        .wr_set    (wr_ok && hit(bus_addr, OFS_HE_MSET)),
        .wr_clr    (wr_ok && hit(bus_addr, OFS_HE_MCLR)),
        .wdata     ({bus_wdata[1], 1'b0}),
        .raw       (he_raw),
        .mask      (he_mask),
        .masked    (he_mskd)
    );

    dirb_irq_combiner u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_all),
        .pending ((|tx_mskd) || (|rx_mskd) || (|he_mskd)),
        .eoi     (wr_ok && hit(bus_addr, OFS_EOI)),
        .irq     (irq_out)
    );

    // enables, control, offset: kept across a soft reset
    logic [3:0]       ctrl_q;
    logic [OFS_W-1:0] ofs_q;
    logic             txen_q, rxen_q, idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txen_q <= 1'b0;
            rxen_q <= 1'b0;
            ctrl_q <= '0;
            ofs_q  <= '0;
            idle_q <= 1'b0;
        end else begin
            idle_q <= wr_ok && hit(bus_addr, OFS_DMA_CTRL) && bus_wdata[3];
            if (wr_ok && hit(bus_addr, OFS_TX_CTRL))  txen_q <= bus_wdata[0];
            if (wr_ok && hit(bus_addr, OFS_RX_CTRL))  rxen_q <= bus_wdata[0];
            if (wr_ok && hit(bus_addr, OFS_DMA_CTRL))
                ctrl_q <= {bus_wdata[4], bus_wdata[2], bus_wdata[1], bus_wdata[0]};
            if (wr_ok && hit(bus_addr, OFS_RX_OFS))   ofs_q <= bus_wdata[OFS_W-1:0];
        end
    end

    // error fields: engine reports win over software writes
    err_field_t tx_err_q, rx_err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_err_q <= '0;
            rx_err_q <= '0;
        end else if (clr_all) begin
            tx_err_q <= '0;
            rx_err_q <= '0;
        end else begin
            if (tx_err_valid) begin
                tx_err_q <= '{code: tx_err_code, chan: tx_err_chan};
            end else if (wr_ok && hit(bus_addr, OFS_DMA_STAT)) begin
                tx_err_q <= '{code: bus_wdata[23:20], chan: bus_wdata[18:16]};
            end
            if (rx_err_valid) begin
                rx_err_q <= '{code: rx_err_code, chan: rx_err_chan};
            end else if (wr_ok && hit(bus_addr, OFS_DMA_STAT)) begin
                rx_err_q <= '{code: bus_wdata[15:12], chan: bus_wdata[10:8]};
            end
        end
    end

    // teardown requests
    logic [NUM_CH-1:0] tx_td_q, rx_td_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_td_q <= '0;
            rx_td_q <= '0;
        end else begin
            tx_td_q <= (wr_ok && hit(bus_addr, OFS_TX_TD))
                       ? (NUM_CH'(1) << bus_wdata[CH_W-1:0]) : '0;
            rx_td_q <= (wr_ok && hit(bus_addr, OFS_RX_TD))
                       ? (NUM_CH'(1) << bus_wdata[CH_W-1:0]) : '0;
        end
    end

    // outputs
    assign chan_reset      = busy;
    assign tx_enable       = txen_q;
    assign rx_enable       = rxen_q;
    assign tx_prio_fixed   = ctrl_q[0];
    assign rx_own_flip     = ctrl_q[1];
    assign rx_len_update   = ctrl_q[2];
    assign copy_err_frames = ctrl_q[3];
    assign idle_cmd        = idle_q;
    assign rx_buf_offset   = ofs_q;
    assign tx_td_req       = tx_td_q;
    assign rx_td_req       = rx_td_q;

    // read mux
    logic [31:0] stat_word;
    assign stat_word = {engine_idle, 7'b0, tx_err_q.code, 1'b0, tx_err_q.chan,
                        rx_err_q.code, 1'b0, rx_err_q.chan, 8'b0};

    always_comb begin
        bus_rdata = '0;
        if      (hit(bus_addr, OFS_TX_CTRL))  bus_rdata = DATA_W'(txen_q);
        else if (hit(bus_addr, OFS_RX_CTRL))  bus_rdata = DATA_W'(rxen_q);
        else if (hit(bus_addr, OFS_SRST))     bus_rdata = DATA_W'(busy);
        else if (hit(bus_addr, OFS_DMA_CTRL))
            bus_rdata = DATA_W'({ctrl_q[3], 1'b0, ctrl_q[2:0]});
        else if (hit(bus_addr, OFS_DMA_STAT)) bus_rdata = DATA_W'(stat_word);
        else if (hit(bus_addr, OFS_RX_OFS))   bus_rdata = DATA_W'(ofs_q);
        else if (hit(bus_addr, OFS_TX_RAW))   bus_rdata = DATA_W'(tx_raw);
        else if (hit(bus_addr, OFS_TX_MSKD))  bus_rdata = DATA_W'(tx_mskd);
        else if (hit(bus_addr, OFS_TX_MSET) || hit(bus_addr, OFS_TX_MCLR))
            bus_rdata = DATA_W'(tx_mask);
        else if (hit(bus_addr, OFS_RX_RAW))   bus_rdata = DATA_W'(rx_raw);
        else if (hit(bus_addr, OFS_RX_MSKD))  bus_rdata = DATA_W'(rx_mskd);
        else if (hit(bus_addr, OFS_RX_MSET) || hit(bus_addr, OFS_RX_MCLR))
            bus_rdata = DATA_W'(rx_mask);
        else if (hit(bus_addr, OFS_HE_RAW))   bus_rdata = DATA_W'(he_raw);
        else if (hit(bus_addr, OFS_HE_MSKD))  bus_rdata = DATA_W'(he_mskd);
        else if (hit(bus_addr, OFS_HE_MSET) || hit(bus_addr, OFS_HE_MCLR))
            bus_rdata = DATA_W'(he_mask);
    end

    assert_td_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_td_req) && $onehot0(rx_td_req));
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable({txen_q, rxen_q, ctrl_q, ofs_q}));
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable({txen_q, rxen_q, ctrl_q, ofs_q}) && !idle_q
                  && tx_td_q == '0 && rx_td_q == '0));
endmodule

// File: tb/dma_irq_regbank_tb.sv
module dma_irq_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_done_pulse = '0, tx_ack_pulse = '0, rx_done_pulse = '0, rx_ack_pulse = '0;
    logic        tx_err_valid = 1'b0, rx_err_valid = 1'b0, host_err_ack = 1'b0, engine_idle = 1'b0;
    logic [3:0]  tx_err_code = '0, rx_err_code = '0;
    logic [2:0]  tx_err_chan = '0, rx_err_chan = '0;
    logic        irq_out, chan_reset, tx_enable, rx_enable, tx_prio_fixed, rx_own_flip;
    logic        rx_len_update, copy_err_frames, idle_cmd;
    logic [15:0] rx_buf_offset;
    logic [7:0]  tx_td_req, rx_td_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_regbank dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit started = 0;

    // ---------------- reference model ----------------
    logic [7:0]  m_txraw, m_txmask, m_rxraw, m_rxmask;
    logic        m_hraw, m_hmask, m_fired, m_txen, m_rxen, m_prio, m_flip, m_lenup, m_copy, m_idle;
    logic [3:0]  m_tcode, m_rcode;
    logic [2:0]  m_tch, m_rch;
    logic [15:0] m_ofs;
    logic [7:0]  m_txtd, m_rxtd;
    int          m_rcnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_txraw = 0; m_txmask = 0; m_rxraw = 0; m_rxmask = 0; m_hraw = 0; m_hmask = 0;
            m_fired = 0; m_txen = 0; m_rxen = 0; m_prio = 0; m_flip = 0; m_lenup = 0;
            m_copy = 0; m_idle = 0; m_tcode = 0; m_rcode = 0; m_tch = 0; m_rch = 0;
            m_ofs = 0; m_txtd = 0; m_rxtd = 0; m_rcnt = -1;
        end else begin
            bit wok, start, clr, anym;
            wok   = bus_we && (m_rcnt < 0);
            start = wok && bus_addr == 8'h1C && bus_wdata[0];
            clr   = start || (m_rcnt >= 0);
            anym  = ((m_txraw & m_txmask) != 0) || ((m_rxraw & m_rxmask) != 0) || (m_hraw && m_hmask);
            if (clr) m_fired = 0;
            else if (m_fired) begin if (wok && bus_addr == 8'h94) m_fired = 0; end
            else if (anym) m_fired = 1;
            if (m_rcnt >= 0) m_rcnt = (m_rcnt == 0) ? -1 : m_rcnt - 1;
            if (start) m_rcnt = 15;
            if (clr) begin
                m_txraw = 0; m_txmask = 0; m_rxraw = 0; m_rxmask = 0; m_hraw = 0; m_hmask = 0;
                m_tcode = 0; m_tch = 0; m_rcode = 0; m_rch = 0;
            end else begin
                m_txraw = (m_txraw & ~tx_ack_pulse) | tx_done_pulse;
                m_rxraw = (m_rxraw & ~rx_ack_pulse) | rx_done_pulse;
                m_hraw  = (m_hraw & !host_err_ack) | tx_err_valid | rx_err_valid;
                if (wok && bus_addr == 8'h88) m_txmask = m_txmask | bus_wdata[7:0];
                if (wok && bus_addr == 8'h8C) m_txmask = m_txmask & ~bus_wdata[7:0];
                if (wok && bus_addr == 8'hA8) m_rxmask = m_rxmask | bus_wdata[7:0];
                if (wok && bus_addr == 8'hAC) m_rxmask = m_rxmask & ~bus_wdata[7:0];
                if (wok && bus_addr == 8'hB8 && bus_wdata[1]) m_hmask = 1;
                if (wok && bus_addr == 8'hBC && bus_wdata[1]) m_hmask = 0;
                if (wok && bus_addr == 8'h24) begin
                    m_tcode = bus_wdata[23:20]; m_tch = bus_wdata[18:16];
                    m_rcode = bus_wdata[15:12]; m_rch = bus_wdata[10:8];
                end
                if (tx_err_valid) begin m_tcode = tx_err_code; m_tch = tx_err_chan; end
                if (rx_err_valid) begin m_rcode = rx_err_code; m_rch = rx_err_chan; end
            end
            if (wok && bus_addr == 8'h04) m_txen = bus_wdata[0];
            if (wok && bus_addr == 8'h14) m_rxen = bus_wdata[0];
            if (wok && bus_addr == 8'h20) begin
                m_prio = bus_wdata[0]; m_flip = bus_wdata[1]; m_lenup = bus_wdata[2]; m_copy = bus_wdata[4];
            end
            m_idle = wok && bus_addr == 8'h20 && bus_wdata[3];
            if (wok && bus_addr == 8'h28) m_ofs = bus_wdata[15:0];
            m_txtd = (wok && bus_addr == 8'h08) ? (8'd1 << bus_wdata[2:0]) : 8'd0;
            m_rxtd = (wok && bus_addr == 8'h18) ? (8'd1 << bus_wdata[2:0]) : 8'd0;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h04: return {31'b0, m_txen};
            8'h14: return {31'b0, m_rxen};
            8'h1C: return {31'b0, m_rcnt >= 0};
            8'h20: return {27'b0, m_copy, 1'b0, m_lenup, m_flip, m_prio};
            8'h24: return {engine_idle, 7'b0, m_tcode, 1'b0, m_tch, m_rcode, 1'b0, m_rch, 8'b0};
            8'h28: return {16'b0, m_ofs};
            8'h80: return {24'b0, m_txraw};
            8'h84: return {24'b0, m_txraw & m_txmask};
            8'h88, 8'h8C: return {24'b0, m_txmask};
            8'hA0: return {24'b0, m_rxraw};
            8'hA4: return {24'b0, m_rxraw & m_rxmask};
            8'hA8, 8'hAC: return {24'b0, m_rxmask};
            8'hB0: return {30'b0, m_hraw, 1'b0};
            8'hB4: return {30'b0, m_hraw & m_hmask, 1'b0};
            8'hB8, 8'hBC: return {30'b0, m_hmask, 1'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h04, 8'h14: return "R2";
            8'h1C: return "R7";
            8'h20: return "R8";
            8'h24: return "R9";
            8'h28: return "R10";
            8'h08, 8'h18: return "R11";
            8'h80, 8'hA0, 8'hB0: return "R3";
            8'h84, 8'hA4, 8'hB4: return "R5";
            8'h88, 8'h8C, 8'hA8, 8'hAC, 8'hB8, 8'hBC: return "R4";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(bus_rdata == m_read(bus_addr), tag_of(bus_addr), "rdata", bus_rdata, m_read(bus_addr));
            chk(irq_out == m_fired, "R6", "irq_out", 32'(irq_out), 32'(m_fired));
            chk(chan_reset == (m_rcnt >= 0), "R7", "chan_reset", 32'(chan_reset), 32'(m_rcnt >= 0));
            chk({tx_enable, rx_enable} == {m_txen, m_rxen}, "R2", "enables",
                32'({tx_enable, rx_enable}), 32'({m_txen, m_rxen}));
            chk({tx_prio_fixed, rx_own_flip, rx_len_update, copy_err_frames, idle_cmd} ==
                {m_prio, m_flip, m_lenup, m_copy, m_idle}, "R8", "ctrl outs",
                32'({tx_prio_fixed, rx_own_flip, rx_len_update, copy_err_frames, idle_cmd}),
                32'({m_prio, m_flip, m_lenup, m_copy, m_idle}));
            chk(rx_buf_offset == m_ofs, "R10", "rx_buf_offset", 32'(rx_buf_offset), 32'(m_ofs));
            chk({tx_td_req, rx_td_req} == {m_txtd, m_rxtd}, "R11", "td_req",
                32'({tx_td_req, rx_td_req}), 32'({m_txtd, m_rxtd}));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d; step(); bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    localparam logic [7:0] ADDRS [21] = '{8'h04, 8'h08, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28,
        8'h80, 8'h84, 8'h88, 8'h8C, 8'h94, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        started = 1;
        // R1: reset state on every mapped address and a few unmapped ones
        for (int i = 0; i < 21; i++) begin
            bus_addr = ADDRS[i]; #2;
            chk(bus_rdata == 0, "R1", "reset read", bus_rdata, 0);
            step();
        end
        chk(!irq_out && !tx_enable && !rx_enable && !chan_reset, "R1", "reset outs",
            32'({irq_out, tx_enable, rx_enable, chan_reset}), 0);
        rd(8'h00); rd(8'h10); rd(8'hFC);                     // R12
        // R2 enables
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h14, 32'h1); rd(8'h04); rd(8'h14);
        wr(8'h04, 32'h0); rd(8'h04);
        // R3 raw status and same-cycle set/ack
        tx_done_pulse = 8'h05; step(); tx_done_pulse = 0; rd(8'h80);
        tx_done_pulse = 8'h04; tx_ack_pulse = 8'h05; step();
        tx_done_pulse = 0; tx_ack_pulse = 0; rd(8'h80);
        rx_done_pulse = 8'h80; step(); rx_done_pulse = 0; rd(8'hA0);
        // R4 mask set/clear, R5 masked, R6 irq
        wr(8'h88, 32'h0C); rd(8'h8C); rd(8'h84);
        wr(8'h8C, 32'h08); rd(8'h88); rd(8'h84);
        repeat (3) rd(8'h84);
        wr(8'h94, 0); rd(8'h84); rd(8'h84);                  // refires: bit 2 still set
        tx_ack_pulse = 8'h04; step(); tx_ack_pulse = 0;
        wr(8'h94, 0); repeat (3) rd(8'h84);                   // stays low
        wr(8'hA8, 32'h80); rd(8'hA4); rd(8'hA4); wr(8'hAC, 32'hFF); wr(8'h94, 0); rd(8'hA4);
        // R9 status and host error
        engine_idle = 1;
        tx_err_valid = 1; tx_err_code = 4'hA; tx_err_chan = 3'd5; step(); tx_err_valid = 0;
        rd(8'h24); rd(8'hB0);
        wr(8'hB8, 32'h3); rd(8'hB4); rd(8'hBC); rd(8'hB4);
        rx_err_valid = 1; rx_err_code = 4'h3; rx_err_chan = 3'd6;
        wr(8'h24, 32'h00F7_F700); rx_err_valid = 0; rd(8'h24);
        host_err_ack = 1; step(); host_err_ack = 0; rd(8'hB0); wr(8'h94, 0);
        engine_idle = 0; rd(8'h24);
        // R8 control and idle pulse
        wr(8'h20, 32'h1F); rd(8'h20); wr(8'h20, 32'h12); rd(8'h20);
        // R10 offset
        wr(8'h28, 32'hABCD_1234); rd(8'h28);
        // R11 teardown
        wr(8'h08, 32'h3); rd(8'h08); wr(8'h18, 32'h7); rd(8'h18);
        // R7 soft reset with writes and pulses inside the window
        wr(8'h88, 32'hFF); tx_done_pulse = 8'hFF; step(); tx_done_pulse = 0;
        wr(8'h1C, 32'h1);
        tx_done_pulse = 8'h11; wr(8'h04, 32'h1); tx_done_pulse = 0;
        wr(8'h88, 32'hFF); wr(8'h20, 32'h08); wr(8'h08, 32'h1);
        for (int i = 0; i < 14; i++) rd(8'h1C);
        rd(8'h1C); rd(8'h80); rd(8'h88); rd(8'h20); rd(8'h28);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            tx_done_pulse = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            tx_ack_pulse  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            rx_done_pulse = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            rx_ack_pulse  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            tx_err_valid  = ($urandom % 16 == 0); tx_err_code = 4'($urandom); tx_err_chan = 3'($urandom);
            rx_err_valid  = ($urandom % 16 == 0); rx_err_code = 4'($urandom); rx_err_chan = 3'($urandom);
            host_err_ack  = ($urandom % 8 == 0);
            engine_idle   = 1'($urandom);
            bus_addr  = ADDRS[$urandom % 21];
            bus_wdata = $urandom;
            bus_we    = ($urandom % 3 == 0);
            if (bus_we && bus_addr == 8'h1C && ($urandom % 4 != 0)) bus_wdata[0] = 1'b0;
            step();
        end
        tx_done_pulse = 0; tx_ack_pulse = 0; rx_done_pulse = 0; rx_ack_pulse = 0;
        tx_err_valid = 0; rx_err_valid = 0; host_err_ack = 0; bus_we = 0;
        repeat (20) step();
        finish_run();
    end
endmodule